// File: doc/BRIEF.md
# Prescaled Trigger Input Latch

This block is the front end of a trigger supervisor. It takes twelve independent first-level trigger lines and brings them into the clock domain. It can require each trigger edge to coincide with a common strobe. Each input can be switched off, and eight of the inputs can be divided down by a programmable prescaler. When the supervisor is ready, the surviving edges are frozen into a single latched pattern. That pattern is then held until the downstream sequencer hands it back.

The latched pattern is the address of one writable lookup table, and each entry of that table has two parts. The class part names which higher-level decisions the event needs. It also carries a reject flag, which throws the pattern away at once and issues no accept. The accept part drives eight first-level accept outputs, which appear a fixed number of cycles after the latch. All of the programming goes through one write port, made of an address and a data word: the lookup entries, the prescale divisors, the input enable mask and the strobe option.

Top module: `trig_latch_top`

## Requirements
- R1: While reset is asserted and right after it is released, `latched_valid`, `latched_pattern`, `trig_class`, `class_valid`, `reject_pulse` and `l1_accept` are all zero.
- R2: The enable mask is loaded by a write with `wr_addr[15:14]=2'b10`, and bit i of `wr_data[11:0]` enables input i. Its reset value is all ones. A rising edge on a disabled input never appears in the latched pattern.
- R3: The strobe option is `wr_data[12]` of that same configuration write. When it is set, a trigger edge is considered only if `strobe_in` is high in the same cycle as the trigger edge, after both have passed through equal synchroniser delay.
- R4: Prescale divisors are loaded by a write with `wr_addr[15:14]=2'b01`, with the input number in `wr_addr[3:0]`. Inputs 0 to 3 keep 20 bits of the divisor and inputs 4 to 7 keep its low 14 bits. A write to inputs 8 to 11 has no effect, and those inputs always pass every edge. A divisor N of 2 or more passes every Nth qualifying edge, and 0 or 1 passes every edge. The count advances on every qualifying edge, whether or not a latch follows, and it restarts from zero when the divisor is written.
- R5: A pattern is latched only when `ts_enable` is high, `cycle_active` is low, no pattern is latched, `fe_busy` is low and `ext_inhibit` is low.
- R6: Once a pattern is latched, `latched_pattern` stays stable and no new edge is taken until `release_latch` is seen. The release clears `latched_valid`, `class_valid` and `l1_accept` at the next edge.
- R7: All inputs that pass in the same cycle are captured together in one pattern. Bit i of `latched_pattern` is input i. The pattern is latched three clock edges after a trigger level change that is set up before the first edge.
- R8: Lookup entries are loaded by a write with `wr_addr[15:14]=2'b00`, with the pattern in `wr_addr[11:0]`. In the data word, `wr_data[10]` is reject, `wr_data[9:8]` is the class and `wr_data[7:0]` is the accept vector. One edge after the latch, `class_valid` rises and `trig_class` shows the class of the latched pattern.
- R9: If the reject bit of the latched entry is set, then one edge after the latch `reject_pulse` is high for exactly one cycle, `latched_valid` is cleared, and `l1_accept` stays zero.
- R10: `l1_accept` is zero until exactly `ACC_LAT` edges after the latch edge. At that edge it takes the accept vector of the latched entry, and it holds that value until release. It is zero whenever nothing is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 12 | First-level trigger lines, asynchronous |
| strobe_in | input | 1 | Common coincidence strobe, asynchronous |
| ts_enable | input | 1 | User enable for accepting triggers |
| cycle_active | input | 1 | Downstream cycle in progress |
| fe_busy | input | 1 | Front-end busy |
| ext_inhibit | input | 1 | External inhibit |
| release_latch | input | 1 | Sequencer frees the latched pattern |
| wr_en | input | 1 | Write strobe for programming |
| wr_addr | input | 16 | Write address, with the target selected by bits 15:14 |
| wr_data | input | 20 | Write data |
| latched_valid | output | 1 | A pattern is latched |
| latched_pattern | output | 12 | The latched trigger pattern |
| trig_class | output | 2 | Class of the latched pattern |
| class_valid | output | 1 | `trig_class` is valid |
| reject_pulse | output | 1 | One-cycle pulse that marks a rejected pattern |
| l1_accept | output | 8 | First-level accept vector |

## Verification
A prescaler counter that has slipped shows up at the ports as a missing latch, or as an extra one, on the very next edge of that input. For that reason the bench tracks every edge it sends through its own divider model, including edges that arrive while the block is locked. A lookup or age state that has gone wrong shows within `ACC_LAT` cycles: the class appears on the wrong edge, a reject appears without its clear, or `l1_accept` takes a value one cycle early or late. The bench samples each of these on the exact edge where it is expected. A latch that does not hold would change `latched_pattern` while a second trigger arrives during lock-out, and the bench checks for that directly.

// File: rtl/trig_latch_pkg.sv
package trig_latch_pkg;
  localparam int N_TRIG   = 12;
  localparam int N_ACC    = 8;
  localparam int WR_AW    = 16;
  localparam int WR_DW    = 20;

  typedef enum logic [1:0] {
    SEL_LUT  = 2'b00,
    SEL_DIV  = 2'b01,
    SEL_CFG  = 2'b10,
    SEL_NONE = 2'b11
  } wr_sel_e;

  typedef struct packed {
    logic             reject;
    logic [1:0]       cls;
    logic [N_ACC-1:0] acc;
  } lut_word_t;
endpackage

// File: rtl/trig_prescale.sv
module trig_prescale #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_in,
  input  logic          div_we,
  input  logic [CW-1:0] div_wdata,
  output logic          pass
);
  logic [CW-1:0] div_q, cnt_q, cnt_d;
  logic          bypass;

  assign bypass = (div_q <= CW'(1));
  assign pass   = edge_in & (bypass | (cnt_q == div_q - CW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (div_we)                  cnt_d = '0;
    else if (edge_in && !bypass) cnt_d = pass ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (div_we) div_q <= div_wdata;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/trig_lut.sv
module trig_lut #(
  parameter int AW = 12,
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trig_latch_top.sv
module trig_latch_top
  import trig_latch_pkg::*;
#(
  parameter int ACC_LAT  = 4,
  parameter int N_WIDE   = 4,
  parameter int N_NARROW = 4,
  parameter int W_WIDE   = 20,
  parameter int W_NARROW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic              strobe_in,
  input  logic              ts_enable,
  input  logic              cycle_active,
  input  logic              fe_busy,
  input  logic              ext_inhibit,
  input  logic              release_latch,
  input  logic              wr_en,
  input  logic [WR_AW-1:0]  wr_addr,
  input  logic [WR_DW-1:0]  wr_data,
  output logic              latched_valid,
  output logic [N_TRIG-1:0] latched_pattern,
  output logic [1:0]        trig_class,
  output logic              class_valid,
  output logic              reject_pulse,
  output logic [N_ACC-1:0]  l1_accept
);
  localparam int AGE_W  = $clog2(ACC_LAT + 2);
  localparam int LUT_DW = $bits(lut_word_t);
  localparam int N_PS   = N_WIDE + N_NARROW;

  wr_sel_e wsel;
  assign wsel = wr_sel_e'(wr_addr[WR_AW-1 -: 2]);

  // synchronisers and edge detect
  logic [N_TRIG-1:0] s1_q, s2_q, s3_q;
  logic [2:0]        st_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0; st_q <= '0;
    end else begin
      s1_q <= trig_in; s2_q <= s1_q; s3_q <= s2_q;
      st_q <= {st_q[1:0], strobe_in};
    end
  end

  // configuration
  logic [N_TRIG-1:0] mask_q;
  logic              sreq_q;
  logic              cfg_we;
  assign cfg_we = wr_en && (wsel == SEL_CFG);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sreq_q <= 1'b0;
    end else if (cfg_we) begin
      mask_q <= wr_data[N_TRIG-1:0];
      sreq_q <= wr_data[N_TRIG];
    end
  end

  logic [N_TRIG-1:0] qual, pass;
  logic              strobe_ok;
  assign strobe_ok = !sreq_q || st_q[1];
  assign qual      = s2_q & ~s3_q & mask_q & {N_TRIG{strobe_ok}};

  for (genvar i = 0; i < N_TRIG; i++) begin : g_in
    if (i < N_PS) begin : g_ps
      localparam int CW = (i < N_WIDE) ? W_WIDE : W_NARROW;
      logic div_we;
      assign div_we = wr_en && (wsel == SEL_DIV) && (wr_addr[3:0] == 4'(i));
      trig_prescale #(.CW(CW)) u_ps (
        .clk(clk), .rst_n(rst_n), .edge_in(qual[i]), .div_we(div_we),
        .div_wdata(wr_data[CW-1:0]), .pass(pass[i])
      );
    end else begin : g_direct
      assign pass[i] = qual[i];
    end
  end

  // lookup table
  logic [LUT_DW-1:0] lut_raw;
  lut_word_t         lut_rd;
  logic [N_TRIG-1:0] pat_q, pat_d;
  trig_lut #(.AW(N_TRIG), .DW(LUT_DW)) u_lut (
    .clk(clk), .we(wr_en && (wsel == SEL_LUT)), .waddr(wr_addr[N_TRIG-1:0]),
    .wdata(wr_data[LUT_DW-1:0]), .raddr(pat_q), .rdata(lut_raw)
  );
  assign lut_rd = lut_word_t'(lut_raw);

  // latch and accept timing
  logic             lat_q, lat_d, clsv_q, clsv_d, rej_q, rej_d, ready, take;
  logic [AGE_W-1:0] age_q, age_d;
  logic [1:0]       cls_q, cls_d;
  logic [N_ACC-1:0] acc_q, acc_d;

  assign ready = ts_enable && !cycle_active && !lat_q && !fe_busy && !ext_inhibit;
  assign take  = ready && (|pass);

  always_comb begin
    lat_d  = lat_q;  pat_d = pat_q;  age_d = age_q;
    clsv_d = clsv_q; cls_d = cls_q;  acc_d = acc_q;
    rej_d  = 1'b0;
    if (lat_q && release_latch) begin
      lat_d = 1'b0; age_d = '0; clsv_d = 1'b0; cls_d = '0; acc_d = '0;
    end else if (take) begin
      lat_d = 1'b1; pat_d = pass; age_d = AGE_W'(1);
    end else if (lat_q) begin
      if (age_q <= AGE_W'(ACC_LAT)) age_d = age_q + AGE_W'(1);
      if (age_q == AGE_W'(1)) begin
        if (lut_rd.reject) begin
          rej_d = 1'b1; lat_d = 1'b0; age_d = '0;
        end else begin
          clsv_d = 1'b1; cls_d = lut_rd.cls;
        end
      end
      if (age_q == AGE_W'(ACC_LAT)) acc_d = lut_rd.acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0; pat_q <= '0; age_q <= '0; clsv_q <= 1'b0;
      cls_q <= '0;   rej_q <= 1'b0; acc_q <= '0;
    end else begin
      lat_q <= lat_d; pat_q <= pat_d; age_q <= age_d; clsv_q <= clsv_d;
      cls_q <= cls_d; rej_q <= rej_d; acc_q <= acc_d;
    end
  end

  assign latched_valid   = lat_q;
  assign latched_pattern = pat_q;
  assign trig_class      = cls_q;
  assign class_valid     = clsv_q;
  assign reject_pulse    = rej_q;
  assign l1_accept       = acc_q;
endmodule

// File: rtl/trig_latch_chk.sv
module trig_latch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ts_enable,
  input logic        cycle_active,
  input logic        fe_busy,
  input logic        ext_inhibit,
  input logic        release_latch,
  input logic        latched_valid,
  input logic [11:0] latched_pattern,
  input logic        reject_pulse,
  input logic [7:0]  l1_accept
);
  AST_ACC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !latched_valid |-> (l1_accept == '0));  // R10
  AST_REJECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reject_pulse |-> (!latched_valid && l1_accept == '0));  // R9
  AST_REJECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_pulse |=> !reject_pulse);  // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_valid && !release_latch) |=>
      (reject_pulse || (latched_valid && $stable(latched_pattern))));  // R6
  AST_LATCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_valid) |->
      $past(ts_enable && !cycle_active && !fe_busy && !ext_inhibit));  // R5
  AST_PATTERN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    latched_valid |-> (latched_pattern != '0));  // R7
endmodule

bind trig_latch_top trig_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ts_enable(ts_enable), .cycle_active(cycle_active),
  .fe_busy(fe_busy), .ext_inhibit(ext_inhibit), .release_latch(release_latch),
  .latched_valid(latched_valid), .latched_pattern(latched_pattern),
  .reject_pulse(reject_pulse), .l1_accept(l1_accept)
);

// File: tb/trig_latch_top_test.sv
module trig_latch_top_test;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] trig_in;
  logic        strobe_in, ts_enable, cycle_active, fe_busy, ext_inhibit, release_latch;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [19:0] wr_data;
  logic        latched_valid, class_valid, reject_pulse;
  logic [11:0] latched_pattern;
  logic [1:0]  trig_class;
  logic [7:0]  l1_accept;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic [11:0] m_mask;
  logic        m_sreq;
  logic [19:0] m_div [8];
  int          m_cnt [8];

  trig_latch_top #(.ACC_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .strobe_in(strobe_in),
    .ts_enable(ts_enable), .cycle_active(cycle_active), .fe_busy(fe_busy),
    .ext_inhibit(ext_inhibit), .release_latch(release_latch), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .latched_valid(latched_valid),
    .latched_pattern(latched_pattern), .trig_class(trig_class),
    .class_valid(class_valid), .reject_pulse(reject_pulse), .l1_accept(l1_accept)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ready_now();
    return ts_enable && !cycle_active && !fe_busy && !ext_inhibit;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [19:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[15:14] == 2'b10) begin m_mask = d[11:0]; m_sreq = d[12]; end
    if (a[15:14] == 2'b01 && a[3:0] < 8) begin
      m_div[a[3:0]] = (a[3:0] < 4) ? d : {6'd0, d[13:0]};
      m_cnt[a[3:0]] = 0;
    end
  endtask

  // expected pattern from the prescale model; advances the counters
  task automatic model(input logic [11:0] p, input bit stb, output logic [11:0] e);
    e = '0;
    for (int i = 0; i < 12; i++) begin
      if (p[i] && m_mask[i] && (!m_sreq || stb)) begin
        if (i >= 8 || m_div[i] <= 1) e[i] = 1'b1;
        else begin
          m_cnt[i]++;
          if (m_cnt[i] == int'(m_div[i])) begin e[i] = 1'b1; m_cnt[i] = 0; end
        end
      end
    end
  endtask

  // drive edges; returns at the negedge after the second rising clock edge
  task automatic fire(input logic [11:0] p, input bit stb);
    @(negedge clk);
    trig_in = p; strobe_in = stb;
    @(negedge clk);
    @(negedge clk);
    trig_in = '0; strobe_in = 1'b0;
  endtask

  task automatic release_it();
    @(negedge clk); release_latch = 1'b1;
    @(negedge clk); release_latch = 1'b0;
    check("R6 release clears latch", latched_valid, 0);
    check("R6 release clears accept", l1_accept, 0);
    @(negedge clk);
  endtask

  task automatic run(input logic [11:0] p, input bit stb, input logic [10:0] w,
                     input string req, input bit rel);
    logic [11:0] e;
    bit          el;
    model(p, stb, e);
    el = ready_now() && (e != 0);
    if (el) wr({4'b0000, e}, {9'd0, w});
    fire(p, stb);
    @(negedge clk);                       // after latch edge
    check({req, " latched_valid"}, latched_valid, el);
    if (el) check("R7 pattern", latched_pattern, e);
    @(negedge clk);                       // one edge later
    if (el) begin
      check("R9 reject pulse", reject_pulse, w[10]);
      check("R8 class_valid", class_valid, !w[10]);
      if (!w[10]) check("R8 class", trig_class, w[9:8]);
      else        check("R9 latch cleared", latched_valid, 0);
    end
    for (int k = 2; k < LAT; k++) @(negedge clk);
    check("R10 accept before latency", l1_accept, 0);
    @(negedge clk);
    check("R10 accept at latency", l1_accept, (el && !w[10]) ? w[7:0] : 8'h00);
    if (rel) release_it();
    else repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] e;
    void'($urandom(32'd1234));
    rst_n = 1'b0; trig_in = '0; strobe_in = 0; ts_enable = 1; cycle_active = 0;
    fe_busy = 0; ext_inhibit = 0; release_latch = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    m_mask = '1; m_sreq = 0;
    for (int i = 0; i < 8; i++) begin m_div[i] = '0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset valid", latched_valid, 0);
    check("R1 reset accept", l1_accept, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset outputs",
          {latched_pattern, trig_class, class_valid, reject_pulse, l1_accept, latched_valid}, 0);

    // basic class and latency
    run(12'h001, 0, 11'h2A5, "R7 single", 1);
    // simultaneous inputs
    run(12'hA01, 0, 11'h13C, "R7 simultaneous", 1);
    // reject
    run(12'h004, 0, 11'h4FF, "R9 reject", 1);

    // hold while latched
    run(12'h010, 0, 11'h011, "R6 first", 0);
    model(12'h020, 0, e);
    fire(12'h020, 0);
    repeat (3) @(negedge clk);
    check("R6 pattern held", latched_pattern, 12'h010);
    release_it();

    // ready conditions
    fe_busy = 1;     run(12'h001, 0, 11'h001, "R5 fe_busy", 1);     fe_busy = 0;
    ext_inhibit = 1; run(12'h001, 0, 11'h001, "R5 inhibit", 1);     ext_inhibit = 0;
    ts_enable = 0;   run(12'h001, 0, 11'h001, "R5 disabled", 1);    ts_enable = 1;
    cycle_active = 1; run(12'h001, 0, 11'h001, "R5 cycle", 1);      cycle_active = 0;

    // mask
    wr(16'h8000, 20'h00FF7);
    run(12'h008, 0, 11'h001, "R2 masked input", 1);
    run(12'h00C, 0, 11'h055, "R2 partly masked", 1);

    // strobe coincidence
    wr(16'h8000, 20'h01FFF);
    run(12'h040, 0, 11'h001, "R3 no strobe", 1);
    run(12'h040, 1, 11'h177, "R3 with strobe", 1);
    wr(16'h8000, 20'h00FFF);

    // prescalers
    wr(16'h4001, 20'h00003);
    for (int k = 0; k < 3; k++) run(12'h002, 0, 11'h0C3, "R4 divide by 3", 1);
    wr(16'h4004, 20'h10003);
    for (int k = 0; k < 3; k++) run(12'h010, 0, 11'h09A, "R4 narrow width", 1);
    wr(16'h4000, 20'hFFFFF);
    run(12'h001, 0, 11'h001, "R4 large divisor", 1);
    wr(16'h4009, 20'h00005);
    for (int k = 0; k < 2; k++) run(12'h200, 0, 11'h1E1, "R4 unprescaled", 1);

    // constrained random
    wr(16'h4000, 20'h0);
    for (int i = 0; i < 8; i++) wr(16'h4000 | 16'(i), 20'($urandom_range(0, 3)));
    for (int it = 0; it < 24; it++) begin
      logic [10:0] w;
      if (it % 6 == 0)
        wr(16'h8000, {7'd0, 1'($urandom_range(0, 1)), 12'($urandom) | 12'h900});
      w = 11'($urandom) & 11'h3FF;
      if ($urandom_range(0, 4) == 0) w[10] = 1'b1;
      run(12'($urandom), 1'($urandom_range(0, 1)), w, "R7 random", 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule